// File: doc/BRIEF.md
# Gated Multi-Channel Pulse Rate Meter

This block measures pulse rates on a bank of trigger lines. Every line passes through a short synchronizer, and each low-to-high transition seen on the sampled line adds one to that channel's running counter. A single gate timer, shared by all channels, closes a measurement interval once every `GATE_CYCLES` clock cycles. At that point a load pulse copies every running counter, with its overflow flag, into a holding register. A clear pulse in the next cycle restarts the running counters. A host reads one channel's held count and overflow flag at a time by driving a channel index. The value it reads stays fixed for the whole of the following interval.

The gate is a three-state machine with the states GT_RUN, GT_LOAD and GT_CLEAR. Its transitions are:
- GT_RUN to GT_LOAD when the gate timer wraps.
- GT_LOAD to GT_CLEAR unconditionally.
- GT_CLEAR to GT_RUN, or to GT_LOAD if the timer wraps again at once, which a period of at least 4 cycles never allows.

With an 80 MHz clock, the default period of 80,000,000 cycles gives a one-second gate. Each reading is a count of `CNT_W` bits (24 by default) plus one overflow bit.

Top module: `rate_meter_bank`

## Requirements
- R1: After reset, and until the first holding-register update, every channel reads count 0 and overflow flag 0.
- R2: Each trigger input is sampled through `SYNC_STAGES` (default 2) flip-flops. One count is added per 0-to-1 transition of the sampled line, so a line held high counts once. A level first sampled at clock edge p is added to the counter at edge p+2.
- R3: The machine enters GT_LOAD `GATE_CYCLES` clock edges after reset release and every `GATE_CYCLES` edges after that. The holding registers update at the edge that ends GT_LOAD, and the running counters restart at the edge that ends GT_CLEAR.
- R4: A held value equals the number of transitions counted in the closed interval, and it stays unchanged until the next update.
- R5: A transition counted at the edge ending GT_LOAD, or at the edge ending GT_CLEAR, belongs to the new interval. No transition is lost or counted twice.
- R6: The counter saturates at 2^CNT_W-1. A transition that arrives while the counter is at that value sets the overflow flag, which is held and read together with the count.
- R7: Count and overflow flag both restart at each interval, so a channel that overflowed reads an exact count in a later interval with fewer transitions.
- R8: `rd_count_o`/`rd_ovf_o` show, combinationally, the held count and flag of the channel whose index is on `rd_sel_i` (index 0 is `trig_i[0]`).
- R9: Channels are independent. A channel with no transitions in an interval reads 0 regardless of activity on the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | NUM_CH | Trigger lines, one per channel |
| rd_sel_i | input | SEL_W | Index of the channel to read |
| rd_count_o | output | CNT_W | Held count of the selected channel |
| rd_ovf_o | output | 1 | Held overflow flag of the selected channel |

## Verification
The assertions check on every cycle that:
- a load pulse is always followed by a clear pulse and only ever coincides with the timer wrap;
- the held values never move outside a load;
- a set overflow flag implies a counter parked at its maximum, and a saturated counter never wraps;
- the edge detector never fires on two consecutive cycles;
- the running counter restarts at no more than one.

Only the bench scenarios show that the held numbers are the right ones. The bench computes, per channel and per interval, the count a reference model expects. It does this under saturating, sparse, alternating-idle and boundary-aligned pulse patterns, including transitions that land exactly in the load and clear cycles. It then compares every channel through the read index.

// File: rtl/rmtr_pkg.sv
package rmtr_pkg;

    // Gate sequencing states shared by the gate controller and its checks.
    typedef enum logic [1:0] {
        GT_RUN   = 2'd0,
        GT_LOAD  = 2'd1,
        GT_CLEAR = 2'd2
    } gate_state_t;

endpackage

// File: rtl/rmtr_edge_sync.sv
module rmtr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign edge_o = sync_q[SYNC_STAGES-1] & ~prev_q;

    // R2: a rising transition is reported for exactly one cycle
    assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/rmtr_gate_fsm.sv
module rmtr_gate_fsm
    import rmtr_pkg::*;
#(
    parameter int GATE_CYCLES = 80_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o,
    output logic clear_o
);
    localparam int              TMR_W = $clog2(GATE_CYCLES);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(GATE_CYCLES - 1);

    gate_state_t       state_q, state_d;
    logic [TMR_W-1:0]  timer_q;
    logic              wrap;

    assign wrap = (timer_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
        end else if (wrap) begin
            timer_q <= '0;
        end else begin
            timer_q <= timer_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GT_RUN:   if (wrap) state_d = GT_LOAD;
            GT_LOAD:  state_d = GT_CLEAR;
            GT_CLEAR: state_d = wrap ? GT_LOAD : GT_RUN;
            default:  state_d = GT_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GT_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load_o  = 1'b0;
        clear_o = 1'b0;
        unique case (state_q)
            GT_RUN:   ;
            GT_LOAD:  load_o  = 1'b1;
            GT_CLEAR: clear_o = 1'b1;
            default:  ;
        endcase
    end

    // R3: restart follows every capture on the next cycle
    assert_clear_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> clear_o);

    // R3: captures line up with the gate timer wrap
    assert_load_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (timer_q == '0));

    // R3: capture and restart never overlap
    assert_pulses_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_o, clear_o}));

endmodule

// File: rtl/rmtr_channel.sv
module rmtr_channel #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             load_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] hold_cnt_o,
    output logic             hold_ovf_o
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_cnt;
    logic             run_ovf;
    logic             carry_q;   // transition seen during the capture cycle

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            run_ovf <= 1'b0;
            carry_q <= 1'b0;
        end else if (clear_i) begin
            run_cnt <= {{(CNT_W-1){1'b0}}, carry_q} + {{(CNT_W-1){1'b0}}, edge_i};
            run_ovf <= 1'b0;
            carry_q <= 1'b0;
        end else if (load_i) begin
            carry_q <= edge_i;
        end else if (edge_i) begin
            if (run_cnt == MAXV) begin
                run_ovf <= 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt_o <= '0;
            hold_ovf_o <= 1'b0;
        end else if (load_i) begin
            hold_cnt_o <= run_cnt;
            hold_ovf_o <= run_ovf;
        end
    end

    // R4: held reading only moves on a capture
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(hold_cnt_o) && $stable(hold_ovf_o)));

    // R6: overflow only with the counter parked at its maximum
    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_ovf |-> (run_cnt == MAXV));

    // R6: a saturated counter never wraps before the restart
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_cnt == MAXV) && !clear_i) |=> (run_cnt == MAXV));

    // R7: restart begins a fresh interval with at most one carried transition
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!run_ovf && (run_cnt <= CNT_W'(1))));

endmodule

// File: rtl/rate_meter_bank.sv
module rate_meter_bank #(
    parameter int NUM_CH      = 16,
    parameter int CNT_W       = 24,
    parameter int GATE_CYCLES = 80_000_000,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] trig_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [CNT_W-1:0]  rd_count_o,
    output logic              rd_ovf_o
);
    localparam int SLOTS = 1 << SEL_W;

    logic             load, clear;
    logic [NUM_CH-1:0] edges;
    logic [CNT_W-1:0] hold_cnt [SLOTS];
    logic             hold_ovf [SLOTS];

    rmtr_gate_fsm #(
        .GATE_CYCLES(GATE_CYCLES)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_o  (load),
        .clear_o (clear)
    );

    for (genvar c = 0; c < SLOTS; c++) begin : g_slot
        if (c < NUM_CH) begin : g_live
            rmtr_edge_sync #(
                .SYNC_STAGES(SYNC_STAGES)
            ) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .trig_i (trig_i[c]),
                .edge_o (edges[c])
            );

            rmtr_channel #(
                .CNT_W(CNT_W)
            ) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .edge_i     (edges[c]),
                .load_i     (load),
                .clear_i    (clear),
                .hold_cnt_o (hold_cnt[c]),
                .hold_ovf_o (hold_ovf[c])
            );
        end else begin : g_pad
            assign hold_cnt[c] = '0;
            assign hold_ovf[c] = 1'b0;
        end
    end

    // R8: combinational channel readout
    always_comb begin
        rd_count_o = hold_cnt[rd_sel_i];
        rd_ovf_o   = hold_ovf[rd_sel_i];
    end

endmodule

// File: tb/test_rate_meter_bank.sv
`timescale 1ns/1ps
module test_rate_meter_bank;
    localparam int NCH  = 4;
    localparam int CW   = 6;
    localparam int GATE = 200;
    localparam int NINT = 6;
    localparam int MAXV = (1 << CW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] trig = '0;
    logic [1:0]     sel = '0;
    logic [CW-1:0]  rd_count;
    logic           rd_ovf;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int model [0:NINT+1][0:NCH-1];
    bit prev [0:NCH-1];

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    rate_meter_bank #(
        .NUM_CH(NCH), .CNT_W(CW), .GATE_CYCLES(GATE), .SYNC_STAGES(2)
    ) i_rate_meter_bank (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .rd_sel_i(sel),
        .rd_count_o(rd_count), .rd_ovf_o(rd_ovf)
    );

    // Stimulus per channel, driven at the negedge after clock edge m.
    function automatic bit want_high(int ch, int m);
        int k;
        k = m / GATE;
        case (ch)
            0:       return (k % 2 == 0) ? (m % 2 == 0) : (m % 9 == 0);
            1:       return (m % (3 + k)) == 0;
            2:       return (k % 2 == 0) && (m % 7 == 0);
            default: return (m % 11 == 0) ||
                            ((k % 2 == 0) && (m == (k + 1) * GATE - 2)) ||
                            ((k % 2 == 1) && (m == (k + 1) * GATE - 1));
        endcase
    endfunction

    function automatic string tag_of(int ch);
        case (ch)
            0:       return "R6 R7";
            1:       return "R4 R8";
            2:       return "R9";
            default: return "R5 R2";
        endcase
    endfunction

    task automatic check(string req, int ch, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ch%0d @cyc %0d: actual %0d expected %0d", req, ch, cyc, act, exp);
        end
    endtask

    task automatic check_all(int k, string extra);
        for (int ch = 0; ch < NCH; ch++) begin
            int n;
            sel = ch[1:0];
            #0.2;
            n = model[k][ch];
            check({extra, " ", tag_of(ch), " count"}, ch, int'(rd_count), (n > MAXV) ? MAXV : n);
            check({extra, " ", tag_of(ch), " ovf"}, ch, int'(rd_ovf), (n > MAXV) ? 1 : 0);
        end
    endtask

    initial begin
        for (int ch = 0; ch < NCH; ch++) prev[ch] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all(0, "R1 reset");
        rst_n = 1'b1;
        while (cyc < NINT * GATE + 4) begin
            int m;
            m = cyc;
            if (m >= GATE && (m % GATE) == 2) check_all(m / GATE, "R3 R4 update");
            if (m >= GATE && (m % GATE) == 0) check_all(m / GATE - 1, "R1 R4 held");
            for (int ch = 0; ch < NCH; ch++) begin
                bit h;
                h = want_high(ch, m);
                if (h && !prev[ch]) begin
                    int k;
                    k = (m + 3 + GATE - 1) / GATE;
                    if (k <= NINT + 1) model[k][ch]++;
                end
                trig[ch] = h;
                prev[ch] = h;
            end
            @(negedge clk);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule